// File: doc/BRIEF.md
# Keyed Set/Clear Status Register Bank

This block is a small bank of memory-mapped control registers. A logical register can be reached through three bus addresses. Writing ones to its set address forces the matching bits to 1. Writing ones to its clear address forces the matching bits to 0. A third address returns the current value and cannot be written. Software can therefore change single bits without a read-modify-write sequence.

Two of the registers are protected by a 16-bit key carried in write-data bits [31:16]. The bits take the write only when the key matches. One protected register has a single address that takes a direct value write of its masked bits. The other has a set/clear pair, and each address of that pair expects its own key.

Addresses, keys and the writable mask are parameters. The bus is synchronous and has address, write enable, write data and combinational read data.

Top module: `keyed_setclr_bank`

## Requirements
- R1: After a synchronous active-high reset, every status bit of the three registers reads 0.
- R2: A write to the plain set address (default 0x00) forces to 1 each bit of the plain status whose write-data bit is 1 and leaves the other bits unchanged. Example: from 0, writing 0x00050000 gives 0x00050000.
- R3: A write to the plain clear address (default 0x04) forces to 0 each bit of the plain status whose write-data bit is 1 and leaves the other bits unchanged. Example: from 0x00050000, writing 0x00040000 gives 0x00010000.
- R4: Writes to status addresses (0x08, 0x28) are ignored. Reads of set, clear and unmapped addresses return 0.
- R5: A write to the single-address keyed register (default 0x10) whose data[31:16] equals 0xD64A copies data[15:0] into the bits of mask 0x0002, so bit 1 follows data bit 1. Bits outside the mask stay 0. A read returns the value in bits [15:0], with bits [31:16] zero.
- R6: A write to 0x10 with any other key leaves that register unchanged.
- R7: A write to the keyed set address (default 0x20) with key 0x2305 sets the low-half bits whose data[15:0] bit is 1. Any other key, including 0x1807, is ignored. Status is read at 0x28 in bits [15:0].
- R8: A write to the keyed clear address (default 0x24) with key 0x1807 clears the low-half bits whose data[15:0] bit is 1. Any other key, including 0x2305, is ignored.
- R9: A write takes effect at the next rising clock edge, and the read data shows the new value in the cycle after that edge.
- R10: While the write enable is low, no status bit changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data; bits [31:16] carry the key for protected registers |
| rdata | output | 32 | Combinational read data for addr |

## Verification
The assertions assume that address, write enable and data are stable around each rising edge, and that one write is a single address in a single cycle. On those terms, the two masks given to a register by one write never overlap. The bench drives every input on the falling edge and issues one write per cycle. A behavioural model checks the read port after every rising edge, with both matching and mismatching keys, including the key of the partner address.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 8;
    localparam int LOW_W  = DATA_W - KEY_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [LOW_W-1:0]  low_t;
    typedef logic [DATA_W-1:0] word_t;

    // one write strobe per decoded, key-qualified target
    typedef struct packed {
        logic plain_set;
        logic plain_clr;
        logic mode_wr;
        logic prot_set;
        logic prot_clr;
    } strobe_t;

    function automatic logic key_match(key_t got, key_t want);
        return got == want;
    endfunction
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] set_eff, clr_eff;

    always_comb begin
        set_eff = set_stb ? set_mask : '0;
        clr_eff = clr_stb ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_eff) & ~clr_eff;
    end

    // R2
    set_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (set_stb && !clr_stb) |=> ((q & $past(set_mask)) == $past(set_mask)));

    // R3
    clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !set_stb) |=> ((q & $past(clr_mask)) == '0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/bank_decode.sv
module bank_decode
    import keyreg_pkg::*;
#(
    parameter addr_t PLAIN_SET = 8'h00,
    parameter addr_t PLAIN_CLR = 8'h04,
    parameter addr_t MODE_ADDR = 8'h10,
    parameter addr_t PROT_SET  = 8'h20,
    parameter addr_t PROT_CLR  = 8'h24,
    parameter key_t  MODE_KEY  = 16'hD64A,
    parameter key_t  SET_KEY   = 16'h2305,
    parameter key_t  CLR_KEY   = 16'h1807
) (
    input  addr_t   addr,
    input  logic    wr_en,
    input  key_t    key,
    output strobe_t stb
);
    always_comb begin
        stb           = '0;
        stb.plain_set = wr_en && (addr == PLAIN_SET);
        stb.plain_clr = wr_en && (addr == PLAIN_CLR);
        stb.mode_wr   = wr_en && (addr == MODE_ADDR) && key_match(key, MODE_KEY);
        stb.prot_set  = wr_en && (addr == PROT_SET)  && key_match(key, SET_KEY);
        stb.prot_clr  = wr_en && (addr == PROT_CLR)  && key_match(key, CLR_KEY);
    end
endmodule

// File: rtl/bank_rdmux.sv
module bank_rdmux
    import keyreg_pkg::*;
#(
    parameter addr_t PLAIN_STS = 8'h08,
    parameter addr_t MODE_ADDR = 8'h10,
    parameter addr_t PROT_STS  = 8'h28
) (
    input  addr_t addr,
    input  word_t plain_q,
    input  low_t  mode_q,
    input  low_t  prot_q,
    output word_t rdata
);
    always_comb begin
        if (addr == PLAIN_STS)      rdata = plain_q;
        else if (addr == MODE_ADDR) rdata = {{KEY_W{1'b0}}, mode_q};
        else if (addr == PROT_STS)  rdata = {{KEY_W{1'b0}}, prot_q};
        else                        rdata = '0;
    end
endmodule

// File: rtl/keyed_setclr_bank.sv
module keyed_setclr_bank
    import keyreg_pkg::*;
#(
    parameter addr_t PLAIN_SET = 8'h00,
    parameter addr_t PLAIN_CLR = 8'h04,
    parameter addr_t PLAIN_STS = 8'h08,
    parameter addr_t MODE_ADDR = 8'h10,
    parameter addr_t PROT_SET  = 8'h20,
    parameter addr_t PROT_CLR  = 8'h24,
    parameter addr_t PROT_STS  = 8'h28,
    parameter key_t  MODE_KEY  = 16'hD64A,
    parameter low_t  MODE_MASK = 16'h0002,
    parameter key_t  SET_KEY   = 16'h2305,
    parameter key_t  CLR_KEY   = 16'h1807
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    strobe_t stb;
    word_t   plain_q;
    low_t    mode_q, prot_q;
    low_t    low_data;
    low_t    mode_set, mode_clr;

    assign low_data = wdata[LOW_W-1:0];
    assign mode_set = low_data & MODE_MASK;
    assign mode_clr = ~low_data & MODE_MASK;

    bank_decode #(
        .PLAIN_SET(PLAIN_SET), .PLAIN_CLR(PLAIN_CLR), .MODE_ADDR(MODE_ADDR),
        .PROT_SET(PROT_SET), .PROT_CLR(PROT_CLR),
        .MODE_KEY(MODE_KEY), .SET_KEY(SET_KEY), .CLR_KEY(CLR_KEY)
    ) dec_i (
        .addr(addr), .wr_en(wr_en), .key(wdata[DATA_W-1:LOW_W]), .stb(stb)
    );

    setclr_reg #(.W(DATA_W)) plain_i (
        .clk(clk), .rst(rst),
        .set_stb(stb.plain_set), .clr_stb(stb.plain_clr),
        .set_mask(wdata), .clr_mask(wdata), .q(plain_q)
    );

    setclr_reg #(.W(LOW_W)) mode_i (
        .clk(clk), .rst(rst),
        .set_stb(stb.mode_wr), .clr_stb(stb.mode_wr),
        .set_mask(mode_set), .clr_mask(mode_clr), .q(mode_q)
    );

    setclr_reg #(.W(LOW_W)) prot_i (
        .clk(clk), .rst(rst),
        .set_stb(stb.prot_set), .clr_stb(stb.prot_clr),
        .set_mask(low_data), .clr_mask(low_data), .q(prot_q)
    );

    bank_rdmux #(
        .PLAIN_STS(PLAIN_STS), .MODE_ADDR(MODE_ADDR), .PROT_STS(PROT_STS)
    ) mux_i (
        .addr(addr), .plain_q(plain_q), .mode_q(mode_q), .prot_q(prot_q),
        .rdata(rdata)
    );

    // R4
    sts_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == PLAIN_STS || addr == PROT_STS))
        |=> ($stable(plain_q) && $stable(prot_q) && $stable(mode_q)));

    // R6
    mode_badkey_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == MODE_ADDR && wdata[31:16] != MODE_KEY) |=> $stable(mode_q));

    // R7
    prot_set_badkey_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == PROT_SET && wdata[31:16] != SET_KEY) |=> $stable(prot_q));

    // R8
    prot_clr_badkey_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == PROT_CLR && wdata[31:16] != CLR_KEY) |=> $stable(prot_q));

    // R5
    mode_outside_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mode_q & ~MODE_MASK) == '0));
endmodule

// File: tb/keyed_setclr_bank_tb_top.sv
module keyed_setclr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_plain = 0;
    logic [15:0] m_mode = 0;
    logic [15:0] m_prot = 0;

    keyed_setclr_bank dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'h08:   return m_plain;
            8'h10:   return {16'h0, m_mode};
            8'h28:   return {16'h0, m_prot};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model (R9 timing)
    always @(posedge clk) begin
        #5;
        if (!rst) check("R9 per-cycle", rdata, model_rd(addr));
    end

    task automatic do_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wdata = d;
        @(posedge clk);
        #1;
        case (a)
            8'h00: m_plain = m_plain | d;
            8'h04: m_plain = m_plain & ~d;
            8'h10: if (d[31:16] == 16'hD64A) m_mode = (m_mode & ~16'h0002) | (d[15:0] & 16'h0002);
            8'h20: if (d[31:16] == 16'h2305) m_prot = m_prot | d[15:0];
            8'h24: if (d[31:16] == 16'h1807) m_prot = m_prot & ~d[15:0];
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #2;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        rd(8'h08, "R1", 32'h0);
        rd(8'h10, "R1", 32'h0);
        rd(8'h28, "R1", 32'h0);
        // R2 / R3 plain triplet
        do_write(8'h00, 32'h0005_0000); rd(8'h08, "R2", 32'h0005_0000);
        do_write(8'h04, 32'h0004_0000); rd(8'h08, "R3", 32'h0001_0000);
        do_write(8'h00, 32'h8000_0001); rd(8'h08, "R2", 32'h8001_0001);
        // R4 status writes ignored, set/clear read zero
        do_write(8'h08, 32'hFFFF_FFFF); rd(8'h08, "R4", 32'h8001_0001);
        do_write(8'h28, 32'hFFFF_FFFF); rd(8'h28, "R4", 32'h0);
        rd(8'h00, "R4", 32'h0);
        rd(8'h24, "R4", 32'h0);
        rd(8'h3C, "R4", 32'h0);
        // R10 idle bus with write-looking data
        @(negedge clk); addr = 8'h04; wdata = 32'hFFFF_FFFF; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        rd(8'h08, "R10", 32'h8001_0001);
        // R5 / R6 single-address keyed register
        do_write(8'h10, 32'hD64A_0002); rd(8'h10, "R5", 32'h0000_0002);
        do_write(8'h10, 32'h1234_0000); rd(8'h10, "R6", 32'h0000_0002);
        do_write(8'h10, 32'hD64B_0000); rd(8'h10, "R6", 32'h0000_0002);
        do_write(8'h10, 32'hD64A_0000); rd(8'h10, "R5", 32'h0);
        do_write(8'h10, 32'hD64A_FFFF); rd(8'h10, "R5", 32'h0000_0002);
        do_write(8'h10, 32'h0000_0000); rd(8'h10, "R6", 32'h0000_0002);
        // R7 / R8 keyed set/clear pair
        do_write(8'h20, 32'h2305_0080); rd(8'h28, "R7", 32'h0000_0080);
        do_write(8'h20, 32'h1807_0001); rd(8'h28, "R7", 32'h0000_0080);
        do_write(8'h20, 32'h2305_0101); rd(8'h28, "R7", 32'h0000_0181);
        do_write(8'h24, 32'h2305_0080); rd(8'h28, "R8", 32'h0000_0181);
        do_write(8'h24, 32'h1807_0080); rd(8'h28, "R8", 32'h0000_0101);
        do_write(8'h24, 32'hFFFF_FFFF); rd(8'h28, "R8", 32'h0000_0101);
        // R9 value visible in the first cycle after the write edge
        @(negedge clk); addr = 8'h00; wdata = 32'h0000_0100; wr_en = 1'b1;
        @(posedge clk); #1; m_plain = m_plain | 32'h0000_0100;
        addr = 8'h08; wr_en = 1'b0; #2;
        check("R9", rdata, 32'h8001_0101);
        // R1 reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; m_plain = 0; m_mode = 0; m_prot = 0;
        @(negedge clk); rst = 1'b0;
        rd(8'h08, "R1", 32'h0);
        rd(8'h10, "R1", 32'h0);
        rd(8'h28, "R1", 32'h0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule